// File: doc/BRIEF.md
# Converter result serial readout port

This block sits at the digital edge of a slow delta-sigma converter and hands finished conversion words to an external host over a serial link that the host clocks. A finished word arrives on a parallel bus with a one-cycle valid strobe and two saturation flags. The port range-converts and clamps the word, holds it, and pulls an active-low data-ready line low to tell the host a result is waiting.

The host reads the word by pulling chip select low on a falling edge and then toggling the serial clock. A first rising serial edge arms the shifter. After that, each falling edge moves the next bit onto the serial data line, most significant bit first. If the host deselects part way through, the bit in progress is completed before the data line is released. The host can then read the same word again from the top.

Chip select and serial clock are asynchronous to the system clock. Both pass through two-flop synchronisers, and their edges are detected in the system-clock domain. The host must therefore hold each serial clock phase for several system clocks.

Top module: `conv_readout_port`

## Requirements
- R1: After a synchronous reset, drdy_n is 1, sdata_oe is 0 and sdata is 0.
- R2: A cycle with res_valid high stores a new word, and drdy_n is 0 from the next cycle on, unless R11 applies.
- R3: With bipolar = 1, res_data is read as two's complement and stored as offset binary, which means the most significant bit is inverted. With bipolar = 0, res_data is stored unchanged.
- R4: With sat_hi = 1, the stored word is all ones. With sat_lo = 1 and sat_hi = 0, the stored word is all zeros. This holds in both range modes, and sat_hi wins if both flags are set.
- R5: A falling edge of cs_n is recognised only while drdy_n is 0. A select that falls while drdy_n is 1 leaves sdata_oe at 0, even if a word arrives later while cs_n stays low.
- R6: Within 8 system clocks of a recognised cs_n fall, sdata_oe is 1 and sdata shows the most significant bit of the stored word.
- R7: After a recognised select, falling sclk edges are ignored until a rising sclk edge has occurred.
- R8: Once armed, each falling sclk edge replaces the bit on sdata with the next lower bit, most significant bit first. sdata does not change at any other time during a readout.
- R9: The falling edge that ends the last bit sets drdy_n to 1. After that, sdata is driven to 0 with sdata_oe at 1 until cs_n returns high, and then sdata_oe goes to 0.
- R10: If cs_n rises before all bits are sent, sdata keeps its current bit driven until the next falling sclk edge, and then sdata_oe goes to 0. drdy_n stays 0, and the next readout starts again at the most significant bit.
- R11: A word loaded while no readout is active and drdy_n is 0 overwrites the unread word. drdy_n is then 1 for exactly one cycle, then 0 again, and the new word is the one read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bipolar | input | 1 | Static range select: 1 selects bipolar, 0 selects unipolar |
| res_valid | input | 1 | One-cycle strobe: res_data holds a finished result |
| res_data | input | WORD_W | Finished conversion result |
| sat_hi | input | 1 | Result is above positive full scale |
| sat_lo | input | 1 | Result is below the bottom of the range |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Output enable for the sdata pad driver |
| drdy_n | output | 1 | Data ready, active low |

## Verification
The bench builds the port with WORD_W = 20 rather than the default 16. This makes the bit counter cross a non-power-of-two length and gives the sign inversion a top bit above the 16-bit field. The RTL is also elaborated at the default width. Random words, range modes and saturation flags are each read out in full and compared with a model of the clamp and range rules. Directed sequences cover the unarmed falling edge, an early deselect part way through a word, a select that falls with no data ready, and an overwrite of an unread word.

// File: rtl/rdout_pkg.sv
// Package: shared types for the converter result readout port.
// Assumes nothing beyond IEEE 1800-2017.
package rdout_pkg;

    // Readout sequencer states
    typedef enum logic [2:0] {
        RD_IDLE   = 3'd0,  // no readout, sdata released
        RD_LOAD   = 3'd1,  // copy the held word into the shifter
        RD_ARM    = 3'd2,  // waiting for the arming rising sclk edge
        RD_SHIFT  = 3'd3,  // shifting on falling sclk edges
        RD_FINISH = 3'd4,  // deselected early, completing the current bit
        RD_DONE   = 3'd5   // all bits sent, driving zero until deselect
    } rd_state_e;

endpackage

// File: rtl/rdout_sync.sv
// Module: rdout_sync
// Synchronises N asynchronous single-bit inputs through STAGES flops each
// and flags their rising and falling edges in the destination clock domain.
// Assumes STAGES >= 2 and that inputs stay stable for at least
// STAGES + 1 destination clocks between changes.
module rdout_sync #(
    parameter int unsigned N       = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_chain
        logic [STAGES-1:0] chain_q;

        // Metastability chain for one input bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[i]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[i]};
            end
        end

        assign level_o[i] = chain_q[STAGES-1];
    end

    // Delayed copy of the synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= level_o;
        end
    end

    assign rise_o = level_o & ~prev_q;
    assign fall_o = ~level_o & prev_q;

endmodule

// File: rtl/rdout_clamp.sv
// Module: rdout_clamp
// Converts a raw result to the output coding and applies saturation.
// In bipolar mode the raw value is two's complement and becomes offset
// binary. Over-range forces all ones, under-range all zeros, and
// over-range wins if both flags are set. Purely combinational.
module rdout_clamp #(
    parameter int unsigned WORD_W = 16
) (
    input  logic [WORD_W-1:0] raw_i,
    input  logic              bipolar_i,
    input  logic              sat_hi_i,
    input  logic              sat_lo_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] coded;

    // Range coding: flip the sign bit for offset binary
    always_comb begin
        coded = raw_i;
        if (bipolar_i) begin
            coded[WORD_W-1] = ~raw_i[WORD_W-1];
        end
    end

    // Saturation override, over-range has priority
    always_comb begin
        if (sat_hi_i) begin
            word_o = {WORD_W{1'b1}};
        end else if (sat_lo_i) begin
            word_o = '0;
        end else begin
            word_o = coded;
        end
    end

endmodule

// File: rtl/rdout_shifter.sv
// Module: rdout_shifter
// Readout sequencer and shift register. A start pulse loads the word. A
// rising sclk edge arms shifting, and each falling edge then advances one
// bit, MSB first. Deselect part way through holds the current bit until
// the next falling edge. Assumes start occurs only in RD_IDLE and that the
// edge strobes come from a synchroniser.
module rdout_shifter
    import rdout_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cs_hi_i,
    input  logic              sclk_rise_i,
    input  logic              sclk_fall_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sdata_o,
    output logic              sdata_oe_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int unsigned CNT_W = $clog2(WORD_W + 1);

    rd_state_e         state_q, state_d;
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  left_q;
    logic              shift_now;
    logic              last_bit;

    assign last_bit  = (left_q == CNT_W'(1));
    assign shift_now = (state_q == RD_SHIFT) && !cs_hi_i && sclk_fall_i;
    assign done_o    = shift_now && last_bit;

    // Next-state selection for the readout sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:   if (start_i) state_d = RD_LOAD;
            RD_LOAD:   state_d = RD_ARM;
            RD_ARM: begin
                if (cs_hi_i)          state_d = RD_FINISH;
                else if (sclk_rise_i) state_d = RD_SHIFT;
            end
            RD_SHIFT: begin
                if (cs_hi_i)          state_d = RD_FINISH;
                else if (done_o)      state_d = RD_DONE;
            end
            RD_FINISH: if (sclk_fall_i) state_d = RD_IDLE;
            RD_DONE:   if (cs_hi_i)     state_d = RD_IDLE;
            default:   state_d = RD_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Shift register and remaining-bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            left_q  <= '0;
        end else if (state_q == RD_LOAD) begin
            shreg_q <= word_i;
            left_q  <= CNT_W'(WORD_W);
        end else if (shift_now) begin
            shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
            left_q  <= left_q - CNT_W'(1);
        end
    end

    // Output driver enable covers armed, shifting, finishing and done
    always_comb begin
        unique case (state_q)
            RD_ARM, RD_SHIFT, RD_FINISH, RD_DONE: sdata_oe_o = 1'b1;
            default:                              sdata_oe_o = 1'b0;
        endcase
    end

    assign sdata_o = sdata_oe_o & shreg_q[WORD_W-1];
    assign busy_o  = (state_q != RD_IDLE);

endmodule

// File: rtl/conv_readout_port.sv
// Module: conv_readout_port
// Serial readout port for finished converter words. It holds one clamped
// word, flags it on drdy_n and shifts it out when the host selects the
// port and clocks sclk. Assumes bipolar is static while words are loaded,
// and that each sclk phase lasts at least four system clocks.
module conv_readout_port #(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bipolar,
    input  logic              res_valid,
    input  logic [WORD_W-1:0] res_data,
    input  logic              sat_hi,
    input  logic              sat_lo,
    input  logic              cs_n,
    input  logic              sclk,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              drdy_n
);

    localparam int unsigned NSYNC = 2;  // bit 0: cs_n, bit 1: sclk

    logic [NSYNC-1:0]  sync_lvl, sync_rise, sync_fall;
    logic              cs_hi, cs_fall, sclk_rise, sclk_fall;
    logic [WORD_W-1:0] clamped, word_q;
    logic              busy, done, start;
    logic              reassert_q, fresh_q;

    rdout_sync #(
        .N      (NSYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b01)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({sclk, cs_n}),
        .level_o(sync_lvl),
        .rise_o (sync_rise),
        .fall_o (sync_fall)
    );

    assign cs_hi     = sync_lvl[0];
    assign cs_fall   = sync_fall[0];
    assign sclk_rise = sync_rise[1];
    assign sclk_fall = sync_fall[1];

    rdout_clamp #(.WORD_W(WORD_W)) clamp_i (
        .raw_i    (res_data),
        .bipolar_i(bipolar),
        .sat_hi_i (sat_hi),
        .sat_lo_i (sat_lo),
        .word_o   (clamped)
    );

    // A select edge counts only with data ready and no readout running
    assign start = cs_fall && !drdy_n && !busy;

    rdout_shifter #(.WORD_W(WORD_W)) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .cs_hi_i    (cs_hi),
        .sclk_rise_i(sclk_rise),
        .sclk_fall_i(sclk_fall),
        .word_i     (word_q),
        .sdata_o    (sdata),
        .sdata_oe_o (sdata_oe),
        .busy_o     (busy),
        .done_o     (done)
    );

    // Held result word, replaced on every valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (res_valid) begin
            word_q <= clamped;
        end
    end

    // Marks a word that arrived while a readout was running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh_q <= 1'b0;
        end else if (!busy) begin
            fresh_q <= 1'b0;
        end else if (res_valid) begin
            fresh_q <= 1'b1;
        end
    end

    // Data-ready flag with the one-cycle overwrite pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drdy_n     <= 1'b1;
            reassert_q <= 1'b0;
        end else begin
            reassert_q <= 1'b0;
            if (res_valid && !busy && !drdy_n) begin
                drdy_n     <= 1'b1;
                reassert_q <= 1'b1;
            end else if (res_valid || reassert_q) begin
                drdy_n <= 1'b0;
            end else if (done && !fresh_q) begin
                drdy_n <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rdout_port_chk.sv
// Module: rdout_port_chk
// Property checker for conv_readout_port, attached with bind below.
// Assumes the synchronous active-low reset is applied from time zero.
module rdout_port_chk #(
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bipolar,
    input logic              res_valid,
    input logic [WORD_W-1:0] res_data,
    input logic              sat_hi,
    input logic              sat_lo,
    input logic              sdata,
    input logic              sdata_oe,
    input logic              drdy_n,
    input logic              busy,
    input logic              sclk_fall,
    input logic              cs_hi,
    input logic [WORD_W-1:0] word_q
);

    // R1: leaving reset gives the idle outputs
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (drdy_n && !sdata_oe && !sdata));

    // R2: a load with no word waiting raises data ready
    p_load_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && drdy_n) |=> !drdy_n);

    // R3: bipolar coding inverts the sign bit
    p_offset_bin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && bipolar && !sat_hi && !sat_lo)
        |=> (word_q[WORD_W-1] == !$past(res_data[WORD_W-1])));

    // R4: over-range stores all ones
    p_sat_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && sat_hi) |=> (word_q == {WORD_W{1'b1}}));

    // R4: under-range stores all zeros
    p_sat_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && sat_lo && !sat_hi) |=> (word_q == '0));

    // R5: the driver only turns on with a word waiting
    p_oe_needs_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe) |-> !drdy_n);

    // R8: sdata moves only after a falling serial edge
    p_sdata_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe && $past(sdata_oe) && !$past(sclk_fall)) |-> $stable(sdata));

    // R9: once the word is sent, the line is driven low
    p_done_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(drdy_n) && sdata_oe) |-> !sdata);

    // R10: the driver turns off only on a serial fall or after deselect
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdata_oe) |-> ($past(sclk_fall) || $past(cs_hi)));

    // R11: overwrite of an unread word pulses data ready high
    p_overwrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !drdy_n && !busy) |=> drdy_n);

    // R11: the overwrite pulse lasts a single cycle
    p_pulse_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(res_valid) && $past(!drdy_n) && $past(!busy)) |=> !drdy_n);

endmodule

bind conv_readout_port rdout_port_chk #(.WORD_W(WORD_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bipolar  (bipolar),
    .res_valid(res_valid),
    .res_data (res_data),
    .sat_hi   (sat_hi),
    .sat_lo   (sat_lo),
    .sdata    (sdata),
    .sdata_oe (sdata_oe),
    .drdy_n   (drdy_n),
    .busy     (busy),
    .sclk_fall(sclk_fall),
    .cs_hi    (cs_hi),
    .word_q   (word_q)
);

// File: tb/conv_readout_port_tb_top.sv
// Bench for conv_readout_port: directed corner cases plus seeded random
// words, checked against a model of the clamp and range rules.
module conv_readout_port_tb_top;

    localparam int unsigned W    = 20;
    localparam int unsigned HOLD = 8;   // system clocks per sclk phase

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bipolar = 1'b0;
    logic         res_valid = 1'b0;
    logic [W-1:0] res_data = '0;
    logic         sat_hi = 1'b0;
    logic         sat_lo = 1'b0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic         sdata, sdata_oe, drdy_n;

    int nchk  = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    conv_readout_port #(.WORD_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bipolar(bipolar), .res_valid(res_valid),
        .res_data(res_data), .sat_hi(sat_hi), .sat_lo(sat_lo), .cs_n(cs_n),
        .sclk(sclk), .sdata(sdata), .sdata_oe(sdata_oe), .drdy_n(drdy_n)
    );

    function automatic logic [W-1:0] exp_word(input logic [W-1:0] d,
        input logic bip, input logic sh, input logic sl);
        if (sh) return {W{1'b1}};
        if (sl) return '0;
        return bip ? {~d[W-1], d[W-2:0]} : d;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [W-1:0] d, input logic sh, input logic sl);
        res_data  = d;
        sat_hi    = sh;
        sat_lo    = sl;
        res_valid = 1'b1;
        wait_n(1);
        res_valid = 1'b0;
        sat_hi    = 1'b0;
        sat_lo    = 1'b0;
        wait_n(2);
    endtask

    // Full readout with sclk idling low; returns the captured word
    task automatic read_all(output logic [W-1:0] got);
        cs_n = 1'b0;
        wait_n(HOLD);
        for (int i = 0; i < W; i++) begin
            sclk = 1'b1;
            wait_n(HOLD);
            got[W-1-i] = sdata;
            sclk = 1'b0;
            wait_n(HOLD);
        end
    endtask

    task automatic deselect();
        cs_n = 1'b1;
        wait_n(HOLD);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin : main
        logic [W-1:0] got, wa, wb, ex;
        void'($urandom(32'h0005eed5));
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        // R1: reset state
        check(drdy_n == 1'b1, "R1 drdy_n", 32'(drdy_n), 1);
        check(sdata_oe == 1'b0, "R1 sdata_oe", 32'(sdata_oe), 0);
        check(sdata == 1'b0, "R1 sdata", 32'(sdata), 0);

        // R5: select with nothing ready, then data arrives under select
        cs_n = 1'b0;
        wait_n(HOLD);
        check(sdata_oe == 1'b0, "R5 oe no data", 32'(sdata_oe), 0);
        wa = W'(32'h3c5a1);
        load(wa, 1'b0, 1'b0);
        wait_n(HOLD);
        check(sdata_oe == 1'b0, "R5 oe held select", 32'(sdata_oe), 0);
        check(drdy_n == 1'b0, "R2 drdy after load", 32'(drdy_n), 0);
        deselect();

        // R6, R8, R9: plain unipolar readout
        cs_n = 1'b0;
        wait_n(HOLD);
        check(sdata_oe == 1'b1, "R6 oe on select", 32'(sdata_oe), 1);
        check(sdata == wa[W-1], "R6 first bit", 32'(sdata), 32'(wa[W-1]));
        cs_n = 1'b1;
        wait_n(HOLD);
        sclk = 1'b1;
        wait_n(HOLD);
        sclk = 1'b0;
        wait_n(HOLD);
        check(sdata_oe == 1'b0, "R10 release no shift", 32'(sdata_oe), 0);
        read_all(got);
        check(got == wa, "R8 word", 32'(got), 32'(wa));
        check(drdy_n == 1'b1, "R9 drdy after last", 32'(drdy_n), 1);
        check(sdata_oe == 1'b1 && sdata == 1'b0, "R9 driven low",
              {sdata_oe, sdata}, 32'h2);
        deselect();
        check(sdata_oe == 1'b0, "R9 oe after deselect", 32'(sdata_oe), 0);
        cs_n = 1'b0;
        wait_n(HOLD);
        check(sdata_oe == 1'b0, "R5 select after read", 32'(sdata_oe), 0);
        deselect();

        // R7 and R10: unarmed fall, then early deselect mid bit
        wb = W'(32'ha6d39);
        load(wb, 1'b0, 1'b0);
        sclk = 1'b1;
        wait_n(HOLD);
        cs_n = 1'b0;
        wait_n(HOLD);
        sclk = 1'b0;
        wait_n(HOLD);
        check(sdata == wb[W-1], "R7 unarmed fall ignored",
              32'(sdata), 32'(wb[W-1]));
        sclk = 1'b1;
        wait_n(HOLD);
        sclk = 1'b0;
        wait_n(HOLD);
        check(sdata == wb[W-2], "R8 second bit", 32'(sdata), 32'(wb[W-2]));
        sclk = 1'b1;
        wait_n(HOLD);
        cs_n = 1'b1;
        wait_n(HOLD);
        check(sdata_oe == 1'b1 && sdata == wb[W-2], "R10 bit held",
              {sdata_oe, sdata}, {1'b1, wb[W-2]});
        sclk = 1'b0;
        wait_n(HOLD);
        check(sdata_oe == 1'b0, "R10 released", 32'(sdata_oe), 0);
        check(drdy_n == 1'b0, "R10 drdy kept", 32'(drdy_n), 0);
        read_all(got);
        check(got == wb, "R10 reread from top", 32'(got), 32'(wb));
        deselect();

        // R11: overwrite of an unread word
        load(wa, 1'b0, 1'b0);
        res_data  = wb;
        res_valid = 1'b1;
        wait_n(1);
        res_valid = 1'b0;
        check(drdy_n == 1'b1, "R11 pulse high", 32'(drdy_n), 1);
        wait_n(1);
        check(drdy_n == 1'b0, "R11 pulse one cycle", 32'(drdy_n), 0);
        read_all(got);
        check(got == wb, "R11 new word read", 32'(got), 32'(wb));
        deselect();

        // R3, R4: directed range and clamp cases
        bipolar = 1'b1;
        load(W'(0), 1'b0, 1'b0);
        read_all(got);
        check(got == {1'b1, {(W-1){1'b0}}}, "R3 bipolar zero", 32'(got),
              32'({1'b1, {(W-1){1'b0}}}));
        deselect();
        load(W'(32'h12345), 1'b1, 1'b1);
        read_all(got);
        check(got == {W{1'b1}}, "R4 both flags", 32'(got), 32'({W{1'b1}}));
        deselect();
        load(W'(32'hfffff), 1'b0, 1'b1);
        read_all(got);
        check(got == '0, "R4 under range", 32'(got), 0);
        deselect();

        // R2, R3, R4, R8: seeded random words
        for (int k = 0; k < 40; k++) begin
            logic [W-1:0] d;
            logic sh, sl;
            d       = W'($urandom);
            sh      = ($urandom_range(7) == 0);
            sl      = ($urandom_range(7) == 0);
            bipolar = $urandom_range(1);
            load(d, sh, sl);
            check(drdy_n == 1'b0, "R2 random drdy", 32'(drdy_n), 0);
            ex = exp_word(d, bipolar, sh, sl);
            read_all(got);
            check(got == ex, "R3 R4 random word", 32'(got), 32'(ex));
            deselect();
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule